// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the message-signalled-interrupt capability structure of one device function inside its configuration space. A configuration access port addresses 32-bit dwords with four byte enables. Reads and writes that land inside the structure, which starts at a parameterized dword base, update or return the capability fields. Accesses anywhere else are ignored and read as zero. Two parameters choose 64-bit message addressing and per-vector masking, and these fix the dword layout and which bits can be written.

The block keeps the state that a message generator needs and presents it as plain outputs: the enable flag, the log2 of the allocated vector count, the message address and data, and the mask and pending vectors. A neighbouring generator sets and clears pending bits through two strobe vectors. While message interrupts are enabled, the block blocks the legacy level interrupt request that passes through it.

Top module: `msi_cap_regs`

## Requirements
- R1: The dword layout relative to the base is: control at 0 and address low at 1. With 64-bit addressing, address high is at 2, data at 3, mask at 4 and pending at 5. Without it, data is at 2, mask at 3 and pending at 4. Without masking the structure ends at the data dword. A read or write outside the structure has no effect, and such a read returns zero.
- R2: The control dword reads as follows. Bit 16 is enable, bits [19:17] hold the capable exponent, bits [22:20] hold the enabled exponent, bit 23 is the 64-bit flag and bit 24 is the mask-capable flag. All other bits read zero. Only bit 16 and bits [22:20] are writable, and only when byte enable 2 is set.
- R3: A write of an enabled exponent larger than the capable exponent stores the capable exponent.
- R4: Address bits [1:0] always read as zero. The address high dword is fully writable in 64-bit mode. Otherwise it is absent and the message address bits [63:32] are zero.
- R5: The message data field occupies bits [15:0] of its dword and the upper half reads zero. Every writable field changes only in the bytes whose byte enable is set.
- R6: Only mask bits below the capable vector count (2^exponent) are writable. The other mask bits stay zero.
- R7: When masking is present, a pending-set strobe sets pending bits below the allocated vector count and a pending-clear strobe clears them. Configuration writes never set pending bits.
- R8: When a write lands in the structure and leaves enable set (masking present), pending bits at or above the newly allocated count are cleared in the same update.
- R9: Reset clears enable, the enabled exponent, the address, the data, the mask and the pending bits. The capability flags and the capable exponent still read back.
- R10: The legacy interrupt output follows its input while enable is clear and is held low while enable is set.
- R11: Read data appears on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_dw_addr | input | 6 | Dword address within configuration space |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| pend_set | input | 32 | Pending-set strobes from the message generator |
| pend_clr | input | 32 | Pending-clear strobes from the message generator |
| intx_req_in | input | 1 | Legacy interrupt request from the function |
| cfg_rdata | output | 32 | Read data, valid the cycle after cfg_rd |
| intx_req_out | output | 1 | Legacy interrupt request, gated by enable |
| msi_enable | output | 1 | Message interrupts enabled |
| msi_vec_log2 | output | 3 | Log2 of the allocated vector count |
| msi_addr | output | 64 | Message address |
| msi_data | output | 16 | Message data |
| msi_mask | output | 32 | Per-vector mask bits |
| msi_pend | output | 32 | Per-vector pending bits |

## Verification
A write or pending strobe that is driven between two rising edges is seen on the state outputs after the next rising edge. The bench drives on the falling edge and compares every output at the following falling edge. Read data is registered, so the bench raises the read strobe for one cycle and samples the returned dword one falling edge later. The legacy interrupt gate is combinational, and the bench compares it in the same half-cycle as its input changes.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam int unsigned VEC_N = 32;

    typedef struct packed {
        logic hit;
        logic ctrl;
        logic alo;
        logic ahi;
        logic data;
        logic mask;
        logic pend;
    } msi_sel_t;

    // all-ones below 2^lg vectors
    function automatic logic [VEC_N-1:0] low_ones(input logic [2:0] lg);
        logic [VEC_N-1:0] r;
        r = '0;
        for (int i = 0; i < VEC_N; i++) begin
            if (lg >= 3'd5 || i < (1 << lg)) r[i] = 1'b1;
        end
        return r;
    endfunction

    // byte-enabled merge restricted to a writable mask
    function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be,
                                             input logic [31:0] wmask);
        logic [31:0] bm;
        bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}} & wmask;
        return (old_v & ~bm) | (new_v & bm);
    endfunction

endpackage

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
    import msi_cap_pkg::*;
#(
    parameter bit          IS_64   = 1'b1,
    parameter bit          HAS_MASK = 1'b1,
    parameter int unsigned BASE_DW = 20
) (
    input  logic [5:0] dw_addr,
    output msi_sel_t   sel
);
    localparam int unsigned DW_DATA = IS_64 ? 3 : 2;
    localparam int unsigned DW_MASK = DW_DATA + 1;
    localparam int unsigned DW_PEND = DW_DATA + 2;
    localparam int unsigned DW_LAST = HAS_MASK ? DW_PEND : DW_DATA;

    logic [6:0] rel;

    always_comb begin
        rel = {1'b0, dw_addr} - 7'(BASE_DW);
        sel = '0;
        if ({1'b0, dw_addr} >= 7'(BASE_DW) && rel <= 7'(DW_LAST)) begin
            sel.hit  = 1'b1;
            sel.ctrl = (rel == 7'd0);
            sel.alo  = (rel == 7'd1);
            sel.ahi  = IS_64 && (rel == 7'd2);
            sel.data = (rel == 7'(DW_DATA));
            sel.mask = HAS_MASK && (rel == 7'(DW_MASK));
            sel.pend = HAS_MASK && (rel == 7'(DW_PEND));
        end
    end
endmodule

// File: rtl/msi_cap_vecbank.sv
module msi_cap_vecbank
    import msi_cap_pkg::*;
#(
    parameter bit          HAS_MASK = 1'b1,
    parameter int unsigned CAP_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mask,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    input  logic [2:0]       alloc_q,
    input  logic [2:0]       alloc_d,
    input  logic             trim,
    input  logic [VEC_N-1:0] pend_set,
    input  logic [VEC_N-1:0] pend_clr,
    output logic [VEC_N-1:0] mask_q,
    output logic [VEC_N-1:0] pend_q
);
    localparam logic [2:0] CAP_L = 3'(CAP_LOG2);

    typedef struct packed {
        logic [VEC_N-1:0] mask;
        logic [VEC_N-1:0] pend;
    } vec_state_t;

    generate
        if (HAS_MASK) begin : g_mask
            vec_state_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (wr_mask)
                    st_d.mask = be_merge(st_q.mask, wdata, be, low_ones(CAP_L));
                st_d.pend = (st_q.pend | (pend_set & low_ones(alloc_q))) & ~pend_clr;
                if (trim)
                    st_d.pend = st_d.pend & low_ones(alloc_d);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign mask_q = st_q.mask;
            assign pend_q = st_q.pend;

            AST_TRIM_ABOVE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
                trim |=> ((pend_q & ~low_ones(alloc_q)) == '0)); // R8
            AST_MASK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                ((mask_q & ~low_ones(CAP_L)) == '0)); // R6
        end else begin : g_nomask
            assign mask_q = '0;
            assign pend_q = '0;
        end
    endgenerate
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter bit          IS_64    = 1'b1,
    parameter bit          HAS_MASK = 1'b1,
    parameter int unsigned CAP_LOG2 = 3,
    parameter int unsigned BASE_DW  = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        cfg_rd,
    input  logic [5:0]  cfg_dw_addr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    input  logic [31:0] pend_set,
    input  logic [31:0] pend_clr,
    input  logic        intx_req_in,
    output logic [31:0] cfg_rdata,
    output logic        intx_req_out,
    output logic        msi_enable,
    output logic [2:0]  msi_vec_log2,
    output logic [63:0] msi_addr,
    output logic [15:0] msi_data,
    output logic [31:0] msi_mask,
    output logic [31:0] msi_pend
);
    localparam logic [2:0]  CAP_L   = 3'(CAP_LOG2);
    localparam logic [31:0] ALO_WM  = 32'hFFFF_FFFC;
    localparam logic [31:0] DATA_WM = 32'h0000_FFFF;

    typedef struct packed {
        logic        en;
        logic [2:0]  alloc;
        logic [31:0] alo;
        logic [31:0] ahi;
        logic [15:0] data;
        logic [31:0] rdata;
    } cap_state_t;

    cap_state_t st_d, st_q;
    msi_sel_t   sel;
    logic [31:0] mask_q, pend_q;
    logic [31:0] data_w;
    logic        trim;

    msi_cap_decode #(.IS_64(IS_64), .HAS_MASK(HAS_MASK), .BASE_DW(BASE_DW)) u_decode (
        .dw_addr (cfg_dw_addr),
        .sel     (sel)
    );

    always_comb begin
        st_d   = st_q;
        data_w = '0;
        if (cfg_wr && sel.ctrl && cfg_be[2]) begin
            st_d.en    = cfg_wdata[16];
            st_d.alloc = (cfg_wdata[22:20] > CAP_L) ? CAP_L : cfg_wdata[22:20];
        end
        if (cfg_wr && sel.alo)
            st_d.alo = be_merge(st_q.alo, cfg_wdata, cfg_be, ALO_WM);
        if (IS_64 && cfg_wr && sel.ahi)
            st_d.ahi = be_merge(st_q.ahi, cfg_wdata, cfg_be, '1);
        if (cfg_wr && sel.data) begin
            data_w    = be_merge({16'h0, st_q.data}, cfg_wdata, cfg_be, DATA_WM);
            st_d.data = data_w[15:0];
        end
        trim = HAS_MASK && cfg_wr && sel.hit && st_d.en;

        st_d.rdata = '0;
        if (cfg_rd) begin
            unique case (1'b1)
                sel.ctrl: st_d.rdata = {7'h0, HAS_MASK, IS_64, st_q.alloc, CAP_L, st_q.en, 16'h0};
                sel.alo:  st_d.rdata = st_q.alo;
                sel.ahi:  st_d.rdata = st_q.ahi;
                sel.data: st_d.rdata = {16'h0, st_q.data};
                sel.mask: st_d.rdata = mask_q;
                sel.pend: st_d.rdata = pend_q;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    msi_cap_vecbank #(.HAS_MASK(HAS_MASK), .CAP_LOG2(CAP_LOG2)) u_vecbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_mask  (cfg_wr && sel.mask),
        .be       (cfg_be),
        .wdata    (cfg_wdata),
        .alloc_q  (st_q.alloc),
        .alloc_d  (st_d.alloc),
        .trim     (trim),
        .pend_set (pend_set),
        .pend_clr (pend_clr),
        .mask_q   (mask_q),
        .pend_q   (pend_q)
    );

    assign cfg_rdata    = st_q.rdata;
    assign intx_req_out = intx_req_in && !st_q.en;
    assign msi_enable   = st_q.en;
    assign msi_vec_log2 = st_q.alloc;
    assign msi_addr     = {IS_64 ? st_q.ahi : 32'h0, st_q.alo};
    assign msi_data     = st_q.data;
    assign msi_mask     = mask_q;
    assign msi_pend     = pend_q;

    AST_OUTSIDE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && !sel.hit) |=> (cfg_rdata == '0)); // R1
    AST_CLAMP_EXP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && sel.ctrl && cfg_be[2] && cfg_wdata[22:20] > CAP_L) |=> (msi_vec_log2 == CAP_L)); // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && sel.alo) |=> $stable(msi_addr[31:0])); // R4
    AST_INTX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        msi_enable |-> !intx_req_out); // R10
endmodule

// File: tb/msi_cap_regs_tb.sv
`timescale 1ns/1ps
module msi_cap_regs_tb;
    localparam int unsigned BASE = 20;
    localparam logic [2:0]  CAP  = 3'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [5:0]  cfg_dw_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0, pend_set = '0, pend_clr = '0;
    logic        intx_req_in = 1'b0;
    logic [31:0] cfg_rdata, msi_mask, msi_pend;
    logic        intx_req_out, msi_enable;
    logic [2:0]  msi_vec_log2;
    logic [63:0] msi_addr;
    logic [15:0] msi_data;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // model state
    logic        m_en;
    logic [2:0]  m_alloc;
    logic [31:0] m_alo, m_ahi, m_mask, m_pend;
    logic [15:0] m_data;

    always #4 clk = ~clk;

    msi_cap_regs #(.IS_64(1'b1), .HAS_MASK(1'b1), .CAP_LOG2(3), .BASE_DW(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_dw_addr(cfg_dw_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .pend_set(pend_set), .pend_clr(pend_clr),
        .intx_req_in(intx_req_in), .cfg_rdata(cfg_rdata), .intx_req_out(intx_req_out),
        .msi_enable(msi_enable), .msi_vec_log2(msi_vec_log2), .msi_addr(msi_addr),
        .msi_data(msi_data), .msi_mask(msi_mask), .msi_pend(msi_pend)
    );

    function automatic logic [31:0] lo_ones(input logic [2:0] lg);
        return (lg >= 3'd5) ? 32'hFFFF_FFFF : ((32'd1 << (32'd1 << lg)) - 32'd1);
    endfunction

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be, input logic [31:0] wm);
        logic [31:0] bm;
        bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}} & wm;
        return (o & ~bm) | (n & bm);
    endfunction

    function automatic logic [31:0] exp_read(input logic [5:0] dw);
        int rel;
        rel = int'(dw) - int'(BASE);
        case (rel)
            0: return {7'h0, 1'b1, 1'b1, m_alloc, CAP, m_en, 16'h0};
            1: return m_alo;
            2: return m_ahi;
            3: return {16'h0, m_data};
            4: return m_mask;
            5: return m_pend;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_en = 0; m_alloc = 0; m_alo = 0; m_ahi = 0; m_data = 0; m_mask = 0; m_pend = 0;
    endtask

    task automatic check_outputs(input string req);
        chk(msi_enable == m_en, {req, " enable"}, 64'(msi_enable), 64'(m_en));
        chk(msi_vec_log2 == m_alloc, {req, " alloc"}, 64'(msi_vec_log2), 64'(m_alloc));
        chk(msi_addr == {m_ahi, m_alo}, {req, " addr"}, msi_addr, {m_ahi, m_alo});
        chk(msi_data == m_data, {req, " data"}, 64'(msi_data), 64'(m_data));
        chk(msi_mask == m_mask, {req, " mask"}, 64'(msi_mask), 64'(m_mask));
        chk(msi_pend == m_pend, {req, " pend"}, 64'(msi_pend), 64'(m_pend));
    endtask

    task automatic do_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] w);
        int rel;
        @(negedge clk);
        cfg_wr = 1; cfg_dw_addr = dw; cfg_be = be; cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 0;
        rel = int'(dw) - int'(BASE);
        if (rel >= 0 && rel <= 5) begin
            case (rel)
                0: if (be[2]) begin
                       m_en = w[16];
                       m_alloc = (w[22:20] > CAP) ? CAP : w[22:20];
                   end
                1: m_alo = mrg(m_alo, w, be, 32'hFFFF_FFFC);
                2: m_ahi = mrg(m_ahi, w, be, 32'hFFFF_FFFF);
                3: m_data = 16'(mrg({16'h0, m_data}, w, be, 32'h0000_FFFF));
                4: m_mask = mrg(m_mask, w, be, lo_ones(CAP));
                default: ;
            endcase
            if (m_en) m_pend = m_pend & lo_ones(m_alloc);   // R8
        end
    endtask

    task automatic do_read(input logic [5:0] dw, input string req);
        logic [31:0] e;
        e = exp_read(dw);
        @(negedge clk);
        cfg_rd = 1; cfg_dw_addr = dw;
        @(negedge clk);
        cfg_rd = 0;
        chk(cfg_rdata == e, req, 64'(cfg_rdata), 64'(e));
    endtask

    task automatic do_pend(input logic [31:0] s, input logic [31:0] c);
        @(negedge clk);
        pend_set = s; pend_clr = c;
        @(negedge clk);
        pend_set = 0; pend_clr = 0;
        m_pend = (m_pend | (s & lo_ones(m_alloc))) & ~c;   // R7
    endtask

    task automatic check_intx(input string req);
        for (int k = 0; k < 2; k++) begin
            intx_req_in = k[0];
            #1;
            chk(intx_req_out == (intx_req_in & ~m_en), req, 64'(intx_req_out), 64'(intx_req_in & ~m_en));
        end
        intx_req_in = 0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9 reset state
        check_outputs("R9 reset");
        do_read(6'(BASE), "R2 R9 control after reset");
        check_intx("R10 disabled");

        // R3 clamp with oversized exponent
        do_write(6'(BASE), 4'b0100, 32'h0071_0000);
        check_outputs("R3 clamp");
        do_read(6'(BASE), "R3 control readback");
        check_intx("R10 enabled");

        // R4 low address bits
        do_write(6'(BASE + 1), 4'hF, 32'hFFFF_FFFF);
        check_outputs("R4 addr low");
        // R6 mask range
        do_write(6'(BASE + 4), 4'hF, 32'hFFFF_FFFF);
        check_outputs("R6 mask");
        // R7 pending write ignored
        do_write(6'(BASE + 5), 4'hF, 32'hFFFF_FFFF);
        check_outputs("R7 pend write ignored");
        // R7 pending set and clear
        do_pend(32'hFFFF_FFFF, 32'h0);
        check_outputs("R7 pend set");
        do_pend(32'h0, 32'h0000_0005);
        check_outputs("R7 pend clr");
        // R8 shrinking count trims pending
        do_write(6'(BASE), 4'b0100, 32'h0011_0000);
        check_outputs("R8 trim");
        // R1 outside range ignored
        do_write(6'(BASE + 6), 4'hF, 32'hFFFF_FFFF);
        do_write(6'(BASE - 1), 4'hF, 32'hFFFF_FFFF);
        check_outputs("R1 outside write");
        do_read(6'(BASE + 6), "R1 outside read");
        // R5 data byte enables
        do_write(6'(BASE + 3), 4'b1110, 32'hABCD_1234);
        check_outputs("R5 data bytes");
        do_read(6'(BASE + 3), "R5 R11 data read");

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [5:0] dw;
            dw = 6'(BASE - 2 + ($urandom % 10));
            r  = $urandom;
            case ($urandom % 4)
                0: do_pend($urandom, $urandom & $urandom);
                1: do_read(dw, "R1 R11 random read");
                default: do_write(dw, 4'($urandom), r);
            endcase
            check_outputs("R5 random");
            if (i % 50 == 0) check_intx("R10 random");
        end

        // R9 reset mid-run
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        model_reset();
        check_outputs("R9 mid reset");
        do_read(6'(BASE), "R9 flags kept");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule